// File: doc/BRIEF.md
# 8-bit ALU with nibble carry flags

This unit performs the arithmetic and logic step of a small accumulator machine with an 8-bit data path and some 16-bit pointer arithmetic. Each request carries an operation code, two 16-bit operands and the current flag byte. The unit returns a 16-bit result and the updated flag byte. For 8-bit operations only the low byte of each operand is used, and the upper byte of the result is zero. Operations that work on the accumulator alone take it from `in_a`.

Requests enter on a valid/ready stream and leave on a second valid/ready stream through a single output register. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on the following cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives full throughput with no bubble, and stalls propagate back with no extra storage. While `out_valid` is high and `out_ready` is low, the output payload stays frozen.

Top module: `alu8_core`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A request accepted on a clock edge appears on the output after that edge with `out_valid`=1. `in_ready` equals `!out_valid || out_ready`. While `out_valid`=1 and `out_ready`=0, `out_res` and `out_flags` hold. Every accepted request yields exactly one output, in order.
- R2: Flag byte layout: bit 7 zero (Z), bit 6 subtract (N), bit 5 half carry (H), bit 4 carry (C). Bits 3..0 of `out_flags` are always 0. Operation codes: 0 add, 1 add-with-carry, 2 sub, 3 sub-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 wide add, 11 pointer plus signed offset, 12 decimal adjust, 13 complement, 14 set carry, 15 flip carry. 8-bit operations return 0 in `out_res[15:8]`.
- R3: Add and add-with-carry return (a+b+cin) mod 256, where cin is the incoming C for code 1 and 0 for code 0. They set Z on a zero result and clear N. H is the carry out of bit 3 and C is the carry out of bit 7, both including cin.
- R4: Sub and sub-with-borrow return (a-b-cin) mod 256, with cin as in R3 but for code 3. They set N and Z. H is set when a[3:0] < b[3:0]+cin, and C is set when a < b+cin. Compare sets the same flags as sub without borrow but returns `a` unchanged.
- R5: AND sets H=1 and C=0. OR and XOR set H=0 and C=0. All three set Z from the result and clear N.
- R6: Increment and decrement act on `a` and keep C. Increment clears N and sets H when the result's low nibble is 0. Decrement sets N and sets H when the result's low nibble is 0xF. Both set Z from the result.
- R7: Wide add returns (a+b) mod 65536 and keeps Z. It clears N, sets H on a carry out of bit 11 and sets C on a carry out of bit 15.
- R8: Pointer plus offset returns a plus sign-extended b[7:0], mod 65536. It clears Z and N. H is the carry of a[3:0]+b[3:0] and C is the carry of a[7:0]+b[7:0], both unsigned.
- R9: Decimal adjust with N=0 adds 0x06 when H=1 or a[3:0]>9. It also adds 0x60 and sets C when C=1 or a>0x99, and otherwise keeps C. With N=1 it adds 0x9A if C and H are both set, 0xA0 if only C is set, 0xFA if only H is set, and nothing otherwise, keeping C. In both cases it clears H, keeps N and sets Z from the result.
- R10: Complement returns ~a and sets N and H. Set-carry and flip-carry return `a` unchanged, clear N and H, and set C or invert C respectively. All three keep Z, and complement keeps C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_op | input | 4 | Operation code (R2) |
| in_a | input | 16 | First operand / accumulator / pointer |
| in_b | input | 16 | Second operand / offset |
| in_flags | input | 8 | Current flag byte |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 16 | Result |
| out_flags | output | 8 | Updated flag byte |

## Verification
Every operation code is driven with 4096 requests.

For the 8-bit arithmetic and logic codes, `a` sweeps all 256 values while `b` and the incoming flags vary pseudo-randomly. This exercises nibble carries, byte carries and zero results on both the carry-in and the no-carry-in paths, and separates a half-carry taken from bit 3 from one taken from bit 4.

For decimal adjust, the accumulator and the four flag bits are swept exhaustively, covering every correction branch. For the 16-bit codes, full-width random operands with negative offsets distinguish the bit-11 and low-byte carry rules from a plain 16-bit carry.

Randomized `in_valid` and `out_ready` check that back-pressure neither drops, duplicates nor reorders results.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADC   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SBC   = 4'd3,
    OP_CMP   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_INC   = 4'd8,
    OP_DEC   = 4'd9,
    OP_ADDW  = 4'd10,
    OP_SPOFF = 4'd11,
    OP_DAA   = 4'd12,
    OP_CPL   = 4'd13,
    OP_SETC  = 4'd14,
    OP_FLIPC = 4'd15
  } alu_op_e;

  // flag byte bit positions
  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;
  localparam int NIB = 4;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e          op,
  input  logic [2*W-1:0]   a,
  input  logic [2*W-1:0]   b,
  input  logic [W-1:0]     fin,
  output logic [2*W-1:0]   res,
  output logic [W-1:0]     fout
);
  localparam int WW = 2 * W;
  localparam int WH = WW - NIB;

  logic          cin;
  logic [W-1:0]  a8, b8, r8;
  logic [W:0]    s9, d9;
  logic [NIB:0]  sn, dn;
  logic [WW:0]   s17;
  logic [WH:0]   s13;
  logic [WW-1:0] bext;
  logic          z, n, h, c;

  assign a8   = a[W-1:0];
  assign b8   = b[W-1:0];
  assign cin  = ((op == OP_ADC) || (op == OP_SBC)) && fin[FC];
  assign s9   = {1'b0, a8} + {1'b0, b8} + {{W{1'b0}}, cin};
  assign d9   = {1'b0, a8} - {1'b0, b8} - {{W{1'b0}}, cin};
  assign sn   = {1'b0, a8[NIB-1:0]} + {1'b0, b8[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign dn   = {1'b0, a8[NIB-1:0]} - {1'b0, b8[NIB-1:0]} - {{NIB{1'b0}}, cin};
  assign s17  = {1'b0, a} + {1'b0, b};
  assign s13  = {1'b0, a[WH-1:0]} + {1'b0, b[WH-1:0]};
  assign bext = {{W{b8[W-1]}}, b8};

  always_comb begin
    z   = fin[FZ];
    n   = fin[FN];
    h   = fin[FH];
    c   = fin[FC];
    r8  = '0;
    res = '0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        r8 = s9[W-1:0];
        z = (r8 == '0); n = 1'b0; h = sn[NIB]; c = s9[W];
        res = {{W{1'b0}}, r8};
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        r8 = d9[W-1:0];
        z = (r8 == '0); n = 1'b1; h = dn[NIB]; c = d9[W];
        res = (op == OP_CMP) ? {{W{1'b0}}, a8} : {{W{1'b0}}, r8};
      end
      OP_INC: begin
        r8 = a8 + 1'b1;
        z = (r8 == '0); n = 1'b0; h = (r8[NIB-1:0] == '0);
        res = {{W{1'b0}}, r8};
      end
      OP_DEC: begin
        r8 = a8 - 1'b1;
        z = (r8 == '0); n = 1'b1; h = (r8[NIB-1:0] == '1);
        res = {{W{1'b0}}, r8};
      end
      OP_ADDW: begin
        n = 1'b0; h = s13[WH]; c = s17[WW];
        res = s17[WW-1:0];
      end
      OP_SPOFF: begin
        // flags from unsigned low-byte addition, carry-in forced to zero
        z = 1'b0; n = 1'b0; h = sn[NIB]; c = s9[W];
        res = a + bext;
      end
      default: ;
    endcase
    fout     = '0;
    fout[FZ] = z;
    fout[FN] = n;
    fout[FH] = h;
    fout[FC] = c;
  end

  always_comb begin
    if (op == OP_INC || op == OP_DEC)
      AST_INCDEC_KEEPS_C: assert (fout[FC] == fin[FC]) else $error("inc/dec touched C"); // R6
  end
endmodule

// File: rtl/alu8_misc.sv
module alu8_misc
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e          op,
  input  logic [2*W-1:0]   a,
  input  logic [2*W-1:0]   b,
  input  logic [W-1:0]     fin,
  output logic [2*W-1:0]   res,
  output logic [W-1:0]     fout
);
  localparam logic [W-1:0] NINE    = W'(9);
  localparam logic [W-1:0] BCD_MAX = W'(8'h99);

  logic [W-1:0] a8, b8, r8, corr;
  logic         z, n, h, c;

  assign a8 = a[W-1:0];
  assign b8 = b[W-1:0];

  always_comb begin
    z    = fin[FZ];
    n    = fin[FN];
    h    = fin[FH];
    c    = fin[FC];
    corr = '0;
    r8   = '0;
    unique case (op)
      OP_AND: begin r8 = a8 & b8; z = (r8 == '0); n = 1'b0; h = 1'b1; c = 1'b0; end
      OP_OR:  begin r8 = a8 | b8; z = (r8 == '0); n = 1'b0; h = 1'b0; c = 1'b0; end
      OP_XOR: begin r8 = a8 ^ b8; z = (r8 == '0); n = 1'b0; h = 1'b0; c = 1'b0; end
      OP_DAA: begin
        if (!fin[FN]) begin
          if (fin[FH] || ({{(W-NIB){1'b0}}, a8[NIB-1:0]} > NINE)) corr = corr | W'(8'h06);
          if (fin[FC] || (a8 > BCD_MAX)) begin
            corr = corr | W'(8'h60);
            c = 1'b1;
          end
        end else begin
          unique case ({fin[FC], fin[FH]})
            2'b11:   corr = W'(8'h9A);
            2'b10:   corr = W'(8'hA0);
            2'b01:   corr = W'(8'hFA);
            default: corr = '0;
          endcase
        end
        r8 = a8 + corr;
        z = (r8 == '0);
        h = 1'b0;
      end
      OP_CPL:   begin r8 = ~a8; n = 1'b1; h = 1'b1; end
      OP_SETC:  begin r8 = a8; n = 1'b0; h = 1'b0; c = 1'b1; end
      OP_FLIPC: begin r8 = a8; n = 1'b0; h = 1'b0; c = ~fin[FC]; end
      default: ;
    endcase
    res      = {{W{1'b0}}, r8};
    fout     = '0;
    fout[FZ] = z;
    fout[FN] = n;
    fout[FH] = h;
    fout[FC] = c;
  end

  always_comb begin
    if (op == OP_AND)
      AST_AND_HC: assert (fout[FH] && !fout[FC]) else $error("AND flag rule"); // R5
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [2*W-1:0]   in_a,
  input  logic [2*W-1:0]   in_b,
  input  logic [W-1:0]     in_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*W-1:0]   out_res,
  output logic [W-1:0]     out_flags
);
  localparam int WW = 2 * W;

  alu_op_e        op;
  logic [WW-1:0]  ar_res, mi_res, nx_res;
  logic [W-1:0]   ar_flg, mi_flg, nx_flg;
  logic           use_misc;
  logic           take;

  assign op = alu_op_e'(in_op);

  alu8_arith #(.W(W)) i_arith (.op(op), .a(in_a), .b(in_b), .fin(in_flags),
                               .res(ar_res), .fout(ar_flg));
  alu8_misc  #(.W(W)) i_misc  (.op(op), .a(in_a), .b(in_b), .fin(in_flags),
                               .res(mi_res), .fout(mi_flg));

  always_comb begin
    unique case (op)
      OP_AND, OP_OR, OP_XOR, OP_DAA, OP_CPL, OP_SETC, OP_FLIPC: use_misc = 1'b1;
      default: use_misc = 1'b0;
    endcase
    nx_res = use_misc ? mi_res : ar_res;
    nx_flg = use_misc ? mi_flg : ar_flg;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_flags <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_res   <= nx_res;
        out_flags <= nx_flg;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid) else $error("accepted request lost"); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_flags)))
    else $error("output changed under stall"); // R1
  AST_FLAG_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[NIB-1:0] == '0)) else $error("flag low bits set"); // R2
  AST_CMP_PASSES_A: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == OP_CMP) |=> (out_res == {{W{1'b0}}, $past(in_a[W-1:0])}))
    else $error("compare altered result"); // R4
  AST_SETC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == OP_SETC) |=> out_flags[FC]) else $error("set carry"); // R10
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic [7:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_res;
  logic [7:0]  out_flags;

  int errors = 0;
  int checks = 0;
  bit accepted;
  bit done = 0;
  int exp_res_q[$];
  int exp_flg_q[$];
  int exp_op_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res), .out_flags(out_flags)
  );

  function automatic string tag(input int op);
    case (op)
      0, 1:        return "R3";
      2, 3, 4:     return "R4";
      5, 6, 7:     return "R5";
      8, 9:        return "R6";
      10:          return "R7";
      11:          return "R8";
      12:          return "R9";
      default:     return "R10";
    endcase
  endfunction

  function automatic void model(input int op, input int a, input int b, input int f,
                                output int r, output int fo);
    int z, n, h, c, a8, b8, ci, t, corr, sb;
    z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
    a8 = a & 255; b8 = b & 255; r = 0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? c : 0;
        t = a8 + b8 + ci; r = t & 255;
        z = (r == 0); n = 0; h = ((a8 & 15) + (b8 & 15) + ci) > 15; c = t > 255;
      end
      2, 3, 4: begin
        ci = (op == 3) ? c : 0;
        t = (a8 - b8 - ci) & 255;
        r = (op == 4) ? a8 : t;
        z = (t == 0); n = 1; h = (a8 & 15) < ((b8 & 15) + ci); c = a8 < (b8 + ci);
      end
      5: begin r = a8 & b8; z = (r == 0); n = 0; h = 1; c = 0; end
      6: begin r = a8 | b8; z = (r == 0); n = 0; h = 0; c = 0; end
      7: begin r = a8 ^ b8; z = (r == 0); n = 0; h = 0; c = 0; end
      8: begin r = (a8 + 1) & 255; z = (r == 0); n = 0; h = ((r & 15) == 0); end
      9: begin r = (a8 + 255) & 255; z = (r == 0); n = 1; h = ((r & 15) == 15); end
      10: begin
        t = a + b; r = t & 65535;
        n = 0; h = ((a & 4095) + (b & 4095)) > 4095; c = t > 65535;
      end
      11: begin
        sb = (b8 >= 128) ? b8 - 256 : b8;
        r = (a + sb) & 65535;
        z = 0; n = 0; h = ((a & 15) + (b8 & 15)) > 15; c = ((a & 255) + b8) > 255;
      end
      12: begin
        if (n == 0) begin
          corr = 0;
          if (h == 1 || (a8 & 15) > 9) corr = corr + 6;
          if (c == 1 || a8 > 153) begin corr = corr + 96; c = 1; end
          r = (a8 + corr) & 255;
        end else begin
          if (c == 1 && h == 1)  r = (a8 + 154) & 255;
          else if (c == 1)       r = (a8 + 160) & 255;
          else if (h == 1)       r = (a8 + 250) & 255;
          else                   r = a8;
        end
        z = (r == 0); h = 0;
      end
      13: begin r = (~a8) & 255; n = 1; h = 1; end
      14: begin r = a8; n = 0; h = 0; c = 1; end
      default: begin r = a8; n = 0; h = 0; c = 1 - c; end
    endcase
    fo = (z << 7) | (n << 6) | (h << 5) | (c << 4);
  endfunction

  task automatic cycle();
    int er, ef, eo;
    out_ready = ($urandom % 4) != 0;
    #1;
    if (out_valid && out_ready) begin
      if (exp_res_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R1: unexpected output res=%h expected none", out_res);
      end else begin
        er = exp_res_q.pop_front(); ef = exp_flg_q.pop_front(); eo = exp_op_q.pop_front();
        checks++;
        if (int'(out_res) != er || int'(out_flags) != ef) begin
          errors++;
          $display("FAIL %s: op=%0d res=%h flags=%h expected res=%h flags=%h",
                   tag(eo), eo, out_res, out_flags, er[15:0], ef[7:0]);
        end
        checks++;
        if (out_flags[3:0] != 4'h0) begin
          errors++;
          $display("FAIL R2: flags low bits=%h expected 0", out_flags[3:0]);
        end
      end
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      int r, fo;
      model(int'(in_op), int'(in_a), int'(in_b), int'(in_flags), r, fo);
      exp_res_q.push_back(r); exp_flg_q.push_back(fo); exp_op_q.push_back(int'(in_op));
    end
    @(negedge clk);
  endtask

  task automatic send(input int op, input int a, input int b, input int f);
    while (($urandom % 10) == 0) begin in_valid = 1'b0; cycle(); end
    in_op = op[3:0]; in_a = a[15:0]; in_b = b[15:0]; in_flags = f[7:0] & 8'hF0;
    in_valid = 1'b1;
    do cycle(); while (!accepted);
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: reset out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 4096; k++) begin
        int a, b, f;
        if (op == 12) begin
          a = k & 255; b = 0; f = (k >> 8) << 4;
        end else if (op == 10 || op == 11) begin
          a = int'($urandom % 65536); b = int'($urandom % 65536); f = int'($urandom % 256);
          if (k < 4) begin a = 16'hFFFF; b = (k == 0) ? 1 : 16'hFF80 + k; end
        end else begin
          a = k & 255; b = int'($urandom % 256); f = int'($urandom % 256);
          if (k >= 3840) b = a;
        end
        send(op, a, b, f);
      end
    end
    while (exp_res_q.size() != 0) cycle();
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid=%b after drain expected 0", out_valid);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1: watchdog expired pending=%0d expected 0", exp_res_q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule